// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative store of virtual-to-physical page mappings. Every slot keeps a virtual page tag, an 8-bit address-space number, a global flag, a physical page number, a read-permission mask, a write-permission mask and two fault-on-access flags. A lookup takes a virtual page number and the current address-space number. It returns in the same cycle whether the page is mapped, which slot holds it, and the stored translation fields.

Software-visible maintenance arrives as single-cycle commands. An insert writes the next victim slot, which is picked round-robin. A full flush empties the table. A process flush drops every slot that is not global. A page flush drops the slots that would hit for a given page and address space. A short list of the three most recently hit slots is consulted before the full table, and any command empties that list.

Both the command and the lookup sides use a valid/ready handshake. A command is taken when `cmd_valid` and `cmd_ready` are both high. After that the block is busy for exactly one cycle, and `cmd_ready` and `lk_ready` are low during it. A lookup is taken when `lk_valid` and `lk_ready` are both high. A pending command holds off lookups, so the two never take effect in the same cycle. The source must keep a command stable until it is taken. A lookup returns its result combinationally in the cycle it is taken, so the lookup side stores nothing.

Top module: `tlb_asn_xlate`

## Requirements
- R1: After reset, no slot is valid, the victim pointer is at slot 0, the recent list is empty, `busy` is low and `cmd_ready` is high.
- R2: A slot hits only when it is valid, its tag equals `lk_vpn`, and either its global flag is set or its address-space number equals `lk_asn`. On a hit, `lk_ppn`, `lk_rd_perm`, `lk_wr_perm`, `lk_fault_rd` and `lk_fault_wr` carry that slot's stored fields. On a miss, all of these and `lk_slot` are zero.
- R3: When no slot in the recent list hits, the lowest-numbered hitting slot is reported.
- R4: `cmd_op` = 0 inserts. It writes the slot named by the victim pointer with the command's page, address space, global flag and translation fields, marks it valid, and advances the pointer by one. The pointer wraps from the last slot to slot 0.
- R5: `cmd_op` = 1 invalidates every slot and returns the victim pointer to slot 0.
- R6: `cmd_op` = 2 invalidates every slot whose global flag is clear. Global slots stay valid, and the victim pointer does not move.
- R7: `cmd_op` = 3 invalidates exactly the slots that a lookup of `cmd_vpn`/`cmd_asn` would hit under R2. Other slots and the victim pointer are untouched.
- R8: A taken lookup that hits through the table (not through the recent list) puts that slot at the front of a list of at most three slots, and the oldest entry drops off. The list is searched front first before the table. A matching list entry is reported even when a lower-numbered slot also matches. A hit through the list leaves the list unchanged.
- R9: Every taken command empties the recent list.
- R10: `busy` is high for exactly the one cycle after a command is taken. `cmd_ready` is the inverse of `busy`. `lk_ready` is low while `busy` or `cmd_valid` is high. `lk_hit` is high only when a lookup is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 insert, 1 flush all, 2 flush non-global, 3 flush page |
| cmd_vpn | input | VPN_W | Virtual page for insert or page flush |
| cmd_asn | input | ASN_W | Address space for insert or page flush |
| cmd_global | input | 1 | Global flag for insert |
| cmd_ppn | input | PPN_W | Physical page for insert |
| cmd_rd_perm | input | PERM_W | Read permission mask for insert |
| cmd_wr_perm | input | PERM_W | Write permission mask for insert |
| cmd_fault_rd | input | 1 | Fault-on-read flag for insert |
| cmd_fault_wr | input | 1 | Fault-on-write flag for insert |
| busy | output | 1 | Settle cycle after a taken command |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup can be taken |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_asn | input | ASN_W | Current address space |
| lk_hit | output | 1 | Taken lookup found a mapping |
| lk_slot | output | $clog2(N_ENTRY) | Slot that supplied the result |
| lk_ppn | output | PPN_W | Physical page |
| lk_rd_perm | output | PERM_W | Read permission mask |
| lk_wr_perm | output | PERM_W | Write permission mask |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |

## Verification
The assertions assume that the source never raises `cmd_valid` while `busy` is high, and that only one command is taken in any cycle. Under those assumptions the state updates for insert, flush and recent-list clearing can be checked one cycle after the command. The stimulus keeps to these rules because each command is driven for one accepted cycle and then the bench waits out the busy cycle before doing anything else. Random traffic uses small page and address-space ranges. This produces duplicate and global mappings, so the recent-list priority and the selective flushes are exercised often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OP_INSERT     = 2'd0,
    OP_FLUSH_ALL  = 2'd1,
    OP_FLUSH_PROC = 2'd2,
    OP_FLUSH_VPN  = 2'd3
  } tlb_op_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRY = 8,
  localparam int IDX_W = $clog2(N_ENTRY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             clear,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRY - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (clear)   ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))); // R4
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr_q == '0)); // R5
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N_ENTRY = 8,
  parameter int VPN_W   = 20,
  parameter int ASN_W   = 8,
  parameter int PAY_W   = 30,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [ASN_W-1:0]           wr_asn,
  input  logic                       wr_glb,
  input  logic [PAY_W-1:0]           wr_pay,
  input  logic                       flush_all,
  input  logic                       flush_proc,
  input  logic                       flush_vpn,
  input  logic [VPN_W-1:0]           lk_vpn,
  input  logic [ASN_W-1:0]           lk_asn,
  output logic [N_ENTRY-1:0]         match_vec,
  output logic [N_ENTRY*PAY_W-1:0]   pay_flat
);
  logic             v_q   [N_ENTRY];
  logic [VPN_W-1:0] tag_q [N_ENTRY];
  logic [ASN_W-1:0] asn_q [N_ENTRY];
  logic             glb_q [N_ENTRY];
  logic [PAY_W-1:0] pay_q [N_ENTRY];

  logic [N_ENTRY-1:0] valid_vec;
  logic [N_ENTRY-1:0] glb_vec;
  logic [N_ENTRY-1:0] fl_match;

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[i]   <= 1'b0;
        tag_q[i] <= '0;
        asn_q[i] <= '0;
        glb_q[i] <= 1'b0;
        pay_q[i] <= '0;
      end else if (flush_all) begin
        v_q[i] <= 1'b0;
      end else if (sel) begin
        v_q[i]   <= 1'b1;
        tag_q[i] <= wr_vpn;
        asn_q[i] <= wr_asn;
        glb_q[i] <= wr_glb;
        pay_q[i] <= wr_pay;
      end else if (flush_proc && !glb_q[i]) begin
        v_q[i] <= 1'b0;
      end else if (flush_vpn && fl_match[i]) begin
        v_q[i] <= 1'b0;
      end
    end

    assign valid_vec[i] = v_q[i];
    assign glb_vec[i]   = glb_q[i];
    assign match_vec[i] = v_q[i] && (tag_q[i] == lk_vpn) &&
                          (glb_q[i] || (asn_q[i] == lk_asn));
    assign fl_match[i]  = match_vec[i];
    assign pay_flat[i*PAY_W +: PAY_W] = pay_q[i];
  end

  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0)); // R5
  AST_PROC_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_proc |=> (valid_vec == ($past(valid_vec) & $past(glb_vec)))); // R6
  AST_PAGE_FLUSH_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vpn |=> ((valid_vec & $past(fl_match)) == '0)); // R7
  AST_INSERT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush_all) |=> valid_vec[$past(wr_idx)]); // R4
endmodule

// File: rtl/tlb_recent.sv
module tlb_recent #(
  parameter int N_ENTRY = 8,
  parameter int DEPTH   = 3,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               push,
  input  logic [IDX_W-1:0]   push_idx,
  input  logic [N_ENTRY-1:0] match_vec,
  output logic               rc_hit,
  output logic [IDX_W-1:0]   rc_idx
);
  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [DEPTH-1:0] v_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_pos
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[k]   <= 1'b0;
        idx_q[k] <= '0;
      end else if (clear) begin
        v_q[k] <= 1'b0;
      end else if (push) begin
        if (k == 0) begin
          v_q[k]   <= 1'b1;
          idx_q[k] <= push_idx;
        end else begin
          v_q[k]   <= v_q[k-1];
          idx_q[k] <= idx_q[k-1];
        end
      end
    end
  end

  always_comb begin
    rc_hit = 1'b0;
    rc_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (v_q[k] && match_vec[idx_q[k]]) begin
        rc_hit = 1'b1;
        rc_idx = idx_q[k];
      end
    end
  end

  AST_RC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (v_q == '0)); // R9
  AST_RC_HIT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    rc_hit |-> match_vec[rc_idx]); // R8
  AST_RC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !clear) |=> $stable(v_q)); // R8
endmodule

// File: rtl/tlb_asn_xlate.sv
module tlb_asn_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int VPN_W   = 20,
  parameter int ASN_W   = 8,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 4,
  parameter int RECENT  = 3,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [ASN_W-1:0]  cmd_asn,
  input  logic              cmd_global,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic [PERM_W-1:0] cmd_rd_perm,
  input  logic [PERM_W-1:0] cmd_wr_perm,
  input  logic              cmd_fault_rd,
  input  logic              cmd_fault_wr,
  output logic              busy,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_slot,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_rd_perm,
  output logic [PERM_W-1:0] lk_wr_perm,
  output logic              lk_fault_rd,
  output logic              lk_fault_wr
);
  localparam int PAY_W = PPN_W + 2 * PERM_W + 2;

  logic    busy_q, cmd_fire, lk_fire;
  tlb_op_e op;
  logic    do_ins, do_fall, do_fproc, do_fvpn;

  assign cmd_ready = !busy_q;
  assign cmd_fire  = cmd_valid && !busy_q;
  assign lk_ready  = !busy_q && !cmd_valid;
  assign lk_fire   = lk_valid && lk_ready;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= cmd_fire;
  end

  assign op       = tlb_op_e'(cmd_op);
  assign do_ins   = cmd_fire && (op == OP_INSERT);
  assign do_fall  = cmd_fire && (op == OP_FLUSH_ALL);
  assign do_fproc = cmd_fire && (op == OP_FLUSH_PROC);
  assign do_fvpn  = cmd_fire && (op == OP_FLUSH_VPN);

  logic [IDX_W-1:0] victim;

  tlb_victim #(.N_ENTRY(N_ENTRY)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (do_ins),
    .clear   (do_fall),
    .ptr     (victim)
  );

  logic [PAY_W-1:0]         wr_pay;
  logic [N_ENTRY-1:0]       match_vec;
  logic [N_ENTRY*PAY_W-1:0] pay_flat;
  logic [VPN_W-1:0]         q_vpn;
  logic [ASN_W-1:0]         q_asn;

  assign wr_pay = {cmd_ppn, cmd_rd_perm, cmd_wr_perm, cmd_fault_rd, cmd_fault_wr};
  // The page-flush command reuses the match network with its own key.
  assign q_vpn  = do_fvpn ? cmd_vpn : lk_vpn;
  assign q_asn  = do_fvpn ? cmd_asn : lk_asn;

  tlb_entry_array #(
    .N_ENTRY (N_ENTRY),
    .VPN_W   (VPN_W),
    .ASN_W   (ASN_W),
    .PAY_W   (PAY_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (do_ins),
    .wr_idx     (victim),
    .wr_vpn     (cmd_vpn),
    .wr_asn     (cmd_asn),
    .wr_glb     (cmd_global),
    .wr_pay     (wr_pay),
    .flush_all  (do_fall),
    .flush_proc (do_fproc),
    .flush_vpn  (do_fvpn),
    .lk_vpn     (q_vpn),
    .lk_asn     (q_asn),
    .match_vec  (match_vec),
    .pay_flat   (pay_flat)
  );

  logic             pe_hit;
  logic [IDX_W-1:0] pe_idx;

  always_comb begin
    pe_hit = 1'b0;
    pe_idx = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        pe_hit = 1'b1;
        pe_idx = IDX_W'(i);
      end
    end
  end

  logic             rc_hit;
  logic [IDX_W-1:0] rc_idx;

  tlb_recent #(.N_ENTRY(N_ENTRY), .DEPTH(RECENT)) u_recent (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd_fire),
    .push      (lk_fire && !rc_hit && pe_hit),
    .push_idx  (pe_idx),
    .match_vec (match_vec),
    .rc_hit    (rc_hit),
    .rc_idx    (rc_idx)
  );

  logic [IDX_W-1:0] sel_idx;
  logic [PAY_W-1:0] sel_pay;

  assign sel_idx = rc_hit ? rc_idx : pe_idx;
  assign lk_hit  = lk_fire && (rc_hit || pe_hit);
  assign lk_slot = lk_hit ? sel_idx : '0;
  assign sel_pay = lk_hit ? pay_flat[int'(sel_idx)*PAY_W +: PAY_W] : '0;
  assign {lk_ppn, lk_rd_perm, lk_wr_perm, lk_fault_rd, lk_fault_wr} = sel_pay;

  AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_valid); // R10
  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy); // R10
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R10
  AST_HIT_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && !cmd_valid && !busy)); // R10
  AST_HIT_SLOT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> match_vec[lk_slot]); // R2
endmodule

// File: tb/test_tlb_asn_xlate.sv
module test_tlb_asn_xlate;
  localparam int N = 8;
  localparam int VW = 20;
  localparam int AW = 8;
  localparam int PW = 20;
  localparam int MW = 4;
  localparam int IW = 3;
  localparam int YW = PW + 2 * MW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready, cmd_global = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [VW-1:0] cmd_vpn = '0;
  logic [AW-1:0] cmd_asn = '0;
  logic [PW-1:0] cmd_ppn = '0;
  logic [MW-1:0] cmd_rd_perm = '0, cmd_wr_perm = '0;
  logic          cmd_fault_rd = 1'b0, cmd_fault_wr = 1'b0, busy;
  logic          lk_valid = 1'b0, lk_ready, lk_hit;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asn = '0;
  logic [IW-1:0] lk_slot;
  logic [PW-1:0] lk_ppn;
  logic [MW-1:0] lk_rd_perm, lk_wr_perm;
  logic          lk_fault_rd, lk_fault_wr;

  tlb_asn_xlate i_tlb_asn_xlate (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .cmd_global(cmd_global),
    .cmd_ppn(cmd_ppn), .cmd_rd_perm(cmd_rd_perm), .cmd_wr_perm(cmd_wr_perm),
    .cmd_fault_rd(cmd_fault_rd), .cmd_fault_wr(cmd_fault_wr), .busy(busy),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_ppn(lk_ppn),
    .lk_rd_perm(lk_rd_perm), .lk_wr_perm(lk_wr_perm),
    .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr)
  );

  int total = 0;
  int bad = 0;

  // Reference model state
  logic          m_v   [N];
  logic [VW-1:0] m_tag [N];
  logic [AW-1:0] m_asn [N];
  logic          m_g   [N];
  logic [YW-1:0] m_pay [N];
  int            m_ptr;
  int            m_rc  [3];
  logic          m_rcv [3];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mm(int i, logic [VW-1:0] v, logic [AW-1:0] a);
    return m_v[i] && (m_tag[i] == v) && (m_g[i] || (m_asn[i] == a));
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_asn[i] = '0; m_g[i] = 1'b0; m_pay[i] = '0;
    end
    m_ptr = 0;
    for (int k = 0; k < 3; k++) begin m_rc[k] = 0; m_rcv[k] = 1'b0; end
  endfunction

  function automatic void model_cmd(int op, logic [VW-1:0] v, logic [AW-1:0] a,
                                    logic g, logic [YW-1:0] p);
    if (op == 0) begin
      m_v[m_ptr] = 1'b1; m_tag[m_ptr] = v; m_asn[m_ptr] = a;
      m_g[m_ptr] = g; m_pay[m_ptr] = p;
      m_ptr = (m_ptr + 1) % N;
    end else if (op == 1) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_ptr = 0;
    end else if (op == 2) begin
      for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 1'b0;
    end else begin
      bit hits [N];
      for (int i = 0; i < N; i++) hits[i] = mm(i, v, a);
      for (int i = 0; i < N; i++) if (hits[i]) m_v[i] = 1'b0;
    end
    for (int k = 0; k < 3; k++) m_rcv[k] = 1'b0;
  endfunction

  // All tasks start and end just after a falling edge.
  task automatic do_cmd(input int op, input logic [VW-1:0] v, input logic [AW-1:0] a,
                        input logic g, input logic [YW-1:0] p, input string req);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_vpn = v; cmd_asn = a; cmd_global = g;
    {cmd_ppn, cmd_rd_perm, cmd_wr_perm, cmd_fault_rd, cmd_fault_wr} = p;
    lk_valid = 1'b1;
    #1;
    chk(lk_ready == 1'b0, "R10 lk_ready low with command pending", longint'(lk_ready), 0);
    chk(lk_hit == 1'b0, "R10 no hit while command pending", longint'(lk_hit), 0);
    lk_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(op, v, a, g, p);
    #1;
    chk(busy == 1'b1 && cmd_ready == 1'b0 && lk_ready == 1'b0, {req, " / R10 busy after command"},
        longint'({busy, cmd_ready, lk_ready}), 3'b100);
    @(negedge clk);
    #1;
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R10 busy lasts one cycle",
        longint'({busy, cmd_ready}), 2'b01);
  endtask

  task automatic do_look(input logic [VW-1:0] v, input logic [AW-1:0] a, input string req);
    bit e_hit = 1'b0;
    bit via_rc = 1'b0;
    int e_slot = 0;
    lk_valid = 1'b1; lk_vpn = v; lk_asn = a;
    for (int k = 0; k < 3; k++) begin
      if (!e_hit && m_rcv[k] && mm(m_rc[k], v, a)) begin
        e_hit = 1'b1; via_rc = 1'b1; e_slot = m_rc[k];
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!e_hit && mm(i, v, a)) begin e_hit = 1'b1; e_slot = i; end
    end
    #1;
    chk(lk_hit == e_hit, {req, " hit"}, longint'(lk_hit), longint'(e_hit));
    if (e_hit) begin
      chk(int'(lk_slot) == e_slot, {req, " slot"}, longint'(lk_slot), longint'(e_slot));
      chk({lk_ppn, lk_rd_perm, lk_wr_perm, lk_fault_rd, lk_fault_wr} == m_pay[e_slot],
          {req, " / R2 fields"},
          longint'({lk_ppn, lk_rd_perm, lk_wr_perm, lk_fault_rd, lk_fault_wr}),
          longint'(m_pay[e_slot]));
    end else begin
      chk({lk_slot, lk_ppn, lk_rd_perm, lk_wr_perm, lk_fault_rd, lk_fault_wr} == '0,
          "R2 miss outputs zero",
          longint'({lk_slot, lk_ppn, lk_rd_perm, lk_wr_perm, lk_fault_rd, lk_fault_wr}), 0);
    end
    @(negedge clk);
    lk_valid = 1'b0;
    if (e_hit && !via_rc) begin
      m_rc[2] = m_rc[1]; m_rcv[2] = m_rcv[1];
      m_rc[1] = m_rc[0]; m_rcv[1] = m_rcv[0];
      m_rc[0] = e_slot;  m_rcv[0] = 1'b1;
    end
  endtask

  function automatic logic [YW-1:0] rpay();
    return YW'({$urandom, $urandom});
  endfunction

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [YW-1:0] p;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(busy == 1'b0 && cmd_ready == 1'b1 && lk_ready == 1'b1, "R1 handshake after reset",
        longint'({busy, cmd_ready, lk_ready}), 3'b011);
    do_look(20'h0, 8'h0, "R1 empty table");

    // R2/R4: basic insert and address-space rule
    do_cmd(0, 20'h5, 8'h1, 1'b0, rpay(), "R4 insert slot0");
    do_look(20'h5, 8'h1, "R2 same space hits");
    do_look(20'h5, 8'h2, "R2 other space misses");
    do_look(20'h6, 8'h1, "R2 other page misses");
    do_cmd(0, 20'h9, 8'h3, 1'b1, rpay(), "R4 insert global slot1");
    do_look(20'h9, 8'h77, "R2 global any space");
    // Idle lookup gives nothing
    lk_vpn = 20'h9; lk_asn = 8'h3; #1;
    chk(lk_hit == 1'b0, "R10 no hit without lk_valid", longint'(lk_hit), 0);
    @(negedge clk);

    // R8/R3/R9: recent list priority over lowest index
    do_cmd(0, 20'hC, 8'h5, 1'b0, rpay(), "R4 insert slot2");
    do_cmd(0, 20'hC, 8'h0, 1'b1, rpay(), "R4 insert global slot3");
    do_look(20'hC, 8'h7, "R8 only global matches");
    do_look(20'hC, 8'h5, "R8 recent slot wins");
    do_cmd(0, 20'h14, 8'h1, 1'b0, rpay(), "R9 insert empties recent");
    do_look(20'hC, 8'h5, "R3 lowest index after clear");

    // R6 process flush
    do_cmd(2, 20'h0, 8'h0, 1'b0, '0, "R6 flush non-global");
    do_look(20'h9, 8'h7, "R6 global kept");
    do_look(20'h5, 8'h1, "R6 non-global dropped");
    do_look(20'h14, 8'h1, "R6 non-global dropped");

    // R7 page flush
    do_cmd(0, 20'h14, 8'h1, 1'b0, rpay(), "R4 insert slot5");
    do_cmd(0, 20'hC, 8'h5, 1'b0, rpay(), "R4 insert slot6");
    do_cmd(3, 20'h14, 8'h2, 1'b0, '0, "R7 flush non-matching space");
    do_look(20'h14, 8'h1, "R7 other space kept");
    do_cmd(3, 20'hC, 8'h5, 1'b0, '0, "R7 flush page");
    do_look(20'hC, 8'h9, "R7 global match removed");
    do_look(20'hC, 8'h5, "R7 space match removed");
    do_look(20'h9, 8'h1, "R7 other page kept");

    // R4 wrap: slots 7 then 0
    do_cmd(0, 20'h30, 8'h1, 1'b0, rpay(), "R4 insert slot7");
    do_cmd(0, 20'h31, 8'h1, 1'b0, rpay(), "R4 wrap to slot0");
    do_look(20'h30, 8'h1, "R4 last slot");
    do_look(20'h31, 8'h1, "R4 wrapped slot");

    // R5 flush all
    do_cmd(1, 20'h0, 8'h0, 1'b0, '0, "R5 flush all");
    do_look(20'h9, 8'h3, "R5 global gone");
    do_cmd(0, 20'h40, 8'h2, 1'b0, rpay(), "R5 insert after flush");
    do_look(20'h40, 8'h2, "R5 pointer back at slot0");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      logic [VW-1:0] v = VW'($urandom_range(0, 5));
      logic [AW-1:0] a = AW'($urandom_range(0, 2));
      p = rpay();
      if (r < 55)      do_look(v, a, "R2 R3 R8 random lookup");
      else if (r < 85) do_cmd(0, v, a, 1'($urandom_range(0, 1)), p, "R4 random insert");
      else if (r < 88) do_cmd(1, v, a, 1'b0, p, "R5 random flush all");
      else if (r < 93) do_cmd(2, v, a, 1'b0, p, "R6 random flush non-global");
      else             do_cmd(3, v, a, 1'b0, p, "R7 random page flush");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule